// File: doc/BRIEF.md
# NAND Flash Phase Sequencer

This block runs a single NAND flash operation from a one-word phase mask. Software fills a handful of registers: command bytes, the column and row address, a byte count, a chip-enable and ready/busy selection, and a bus-width option. It then writes the control word with its start bit set. The sequencer steps through every phase whose mask bit is set, always in one fixed hardware order. It drives the flash strobes and the IO bus and stalls on the selected ready/busy lines when the mask asks for it.

Page data moves between the flash and an internal byte-wide page buffer that is split into numbered slots. Software reads and writes the buffer as 32-bit words. Inside each word the lowest-addressed byte sits in the most significant lane. Reads of the status byte and of the ID bytes are captured into registers that software can read.

Strobe setup, pulse and hold lengths come from clock-count parameters. The ready/busy pins pass through a two-flop synchroniser before the sequencer uses them.

Top module: `nand_seq_top`

## Requirements
- R1: Phases run only when enabled, and always in this order, with the enable bit for each shown as a bit of CTRL[23:8]: first command (14), column bytes 1 and 2 (13, 12), row bytes 1 to 3 (11, 10, 9), write data (8), second command (7), ready wait (6), read data (5), third command (4), status read (3), ID read (2). A phase whose bit is clear causes no bus cycle.
- R2: Command phases drive CLE high and ALE low, and place a byte on IO[7:0] that the flash latches on the rising edge of WE#. The first command byte is CTRL[31:24] (register 1). The second is OPC[31:24] and the third is OPC[23:16] (register 0).
- R3: Address phases drive ALE high and CLE low. The column bytes are COL[7:0] then COL[15:8] (register 2). The row bytes are ROW[7:0], ROW[15:8] and ROW[23:16] (register 3).
- R4: Every bus cycle holds its strobe high for T_SU clocks, low for T_PW clocks, and high again for T_H clocks. Two back-to-back cycles are therefore T_H+T_SU clocks apart.
- R5: The write-data phase sends LEN bytes (register 4) from buffer slot CTRL[2:1], starting at offset 0. Slot s begins at byte s*BUF_BYTES. Buffer byte k lives in word k/4, and the byte at offset 0 of a word is bits [31:24]. The IO bus is driven during these cycles.
- R6: The read-data phase pulses RE# LEN times. On each pulse it captures IO[7:0] into the next buffer byte of the selected slot. The IO bus is never driven while RE# is low.
- R7: The ready wait lasts T_WB clocks and then continues until every ready/busy line selected by the one-hot field ROW[31:28] reads high after synchronisation. Lines that are not selected are ignored. No strobe moves during the wait.
- R8: The status read captures one byte into STAT[7:0] (register 6). The ID read makes four RE# cycles and shifts them into IDW (register 7), with the first byte ending up in [31:24].
- R9: With CFG bit 7 set (register 5), data phases move two bytes per cycle. The lower-addressed byte goes on IO[7:0], and the phase takes ceil(LEN/2) cycles. Commands and addresses still use IO[7:0] with IO[15:8] at zero.
- R10: ce_n[i] is low exactly while the block is busy and ROW[24+i] is set. It is all ones when idle.
- R11: Writing register 1 with bit 0 set while idle starts an operation. busy rises on the next clock and falls after the last enabled phase. Reads of bit 0 of register 1 return busy, and an empty mask gives a single busy cycle.
- R12: Register writes made while busy are dropped, including a second start. The running operation continues unchanged.
- R13: After reset, CLE and ALE are low, WE# and RE# are high, ce_n is all ones, the IO bus is not driven, and busy is low.
- R14: A data phase with LEN = 0 makes no bus cycle, even if its mask bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| buf_we | input | 1 | Page buffer word write strobe |
| buf_addr | input | BUF_AW | Page buffer word address |
| buf_wdata | input | 32 | Page buffer write word |
| buf_rdata | output | 32 | Page buffer read word (combinational) |
| busy | output | 1 | Operation in progress |
| nand_ce_n | output | NCE | Chip enables, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 16 | IO bus output value |
| nand_io_oe | output | 1 | IO bus output enable |
| nand_io_in | input | 16 | IO bus input value |
| nand_rb_n | input | NCE | Ready/busy lines, low = busy |

## Verification
On every cycle the assertions check the pin rules. CLE and ALE are never high together, and WE# and RE# are never low together. The IO bus is never driven while RE# is low, the strobes stay quiet during a ready wait, and a wait ends only when the selected lines are ready. Chip enables are released whenever the block is idle, and registers do not change while an operation runs. Some behaviour can only be shown by the directed scenarios: the phase order, the byte values and their big-endian placement in the buffer, the measured pulse widths and gaps, the two-byte packing on the wide bus, the skipping of zero-length phases, and the captured status and ID values. These rest on a flash model in the bench that logs each strobe edge and feeds back a known byte stream.

// File: rtl/nseq_pkg.sv
`timescale 1ns/1ps
package nseq_pkg;

  typedef enum logic [3:0] {
    PH_CMD1 = 4'd0, PH_CA1, PH_CA2, PH_RA1, PH_RA2, PH_RA3, PH_WDATA,
    PH_CMD2, PH_WAIT, PH_RDATA, PH_CMD3, PH_STAT, PH_ID, PH_NONE
  } phase_e;

  typedef enum logic [2:0] {S_IDLE, S_SU, S_PW, S_HD, S_WAIT} bus_st_e;

  // first enabled phase at or after 'from'; phase p is gated by mask bit 14-p
  function automatic phase_e next_phase(input logic [15:0] mask, input logic [3:0] from,
                                        input logic len_zero);
    phase_e r;
    r = PH_NONE;
    for (int p = 12; p >= 0; p--) begin
      if (4'(p) >= from && mask[14-p] && !(len_zero && (p == 6 || p == 9)))
        r = phase_e'(p);
    end
    return r;
  endfunction

  function automatic logic is_cmd(input phase_e ph);
    return ph inside {PH_CMD1, PH_CMD2, PH_CMD3};
  endfunction

  function automatic logic is_addr(input phase_e ph);
    return ph inside {PH_CA1, PH_CA2, PH_RA1, PH_RA2, PH_RA3};
  endfunction

  function automatic logic is_read(input phase_e ph);
    return ph inside {PH_RDATA, PH_STAT, PH_ID};
  endfunction

  function automatic logic [15:0] data_units(input logic [15:0] len, input logic wide);
    return wide ? (len + 16'd1) >> 1 : len;
  endfunction

  function automatic logic [15:0] phase_units(input phase_e ph, input logic [15:0] len,
                                              input logic wide);
    case (ph)
      PH_WDATA, PH_RDATA: return data_units(len, wide);
      PH_ID:              return 16'd4;
      default:            return 16'd1;
    endcase
  endfunction

endpackage

// File: rtl/nseq_rb_sync.sv
`timescale 1ns/1ps
module nseq_rb_sync #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] rb_n_in,
  output logic [N-1:0] rb_n_sync
);
  logic [N-1:0] stage1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1    <= '1;
      rb_n_sync <= '1;
    end else begin
      stage1    <= rb_n_in;
      rb_n_sync <= stage1;
    end
  end
endmodule

// File: rtl/nseq_pagebuf.sv
`timescale 1ns/1ps
module nseq_pagebuf #(
  parameter int NBYTES = 1024,
  localparam int BA = $clog2(NBYTES),
  localparam int WA = BA - 2
) (
  input  logic          clk,
  input  logic          sw_we,
  input  logic [WA-1:0] sw_addr,
  input  logic [31:0]   sw_wdata,
  output logic [31:0]   sw_rdata,
  input  logic [BA-1:0] e_addr,
  output logic [15:0]   e_rdata,
  input  logic          e_we_lo,
  input  logic          e_we_hi,
  input  logic [15:0]   e_wdata
);
  logic [7:0] mem [NBYTES];
  logic [BA-1:0] e_addr_hi;
  assign e_addr_hi = e_addr + BA'(1);
  assign e_rdata   = {mem[e_addr_hi], mem[e_addr]};

  // lane k of a word holds byte offset k, offset 0 in the top lane
  for (genvar k = 0; k < 4; k++) begin : g_lane
    assign sw_rdata[31-8*k -: 8] = mem[{sw_addr, 2'(k)}];
  end

  always_ff @(posedge clk) begin
    if (sw_we)
      for (int k = 0; k < 4; k++) mem[{sw_addr, 2'(k)}] <= sw_wdata[31-8*k -: 8];
    if (e_we_lo) mem[e_addr]    <= e_wdata[7:0];
    if (e_we_hi) mem[e_addr_hi] <= e_wdata[15:8];
  end
endmodule

// File: rtl/nseq_engine.sv
`timescale 1ns/1ps
module nseq_engine
  import nseq_pkg::*;
#(
  parameter int T_SU  = 2,
  parameter int T_PW  = 3,
  parameter int T_H   = 2,
  parameter int T_WB  = 4,
  parameter int LEN_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [15:0]      mask,
  input  logic [7:0]       cmd_a,
  input  logic [7:0]       cmd_b,
  input  logic [7:0]       cmd_c,
  input  logic [15:0]      col,
  input  logic [23:0]      row,
  input  logic [LEN_W-1:0] len,
  input  logic             wide,
  input  logic             rb_ready,
  input  logic [15:0]      io_in,
  input  logic [15:0]      buf_rdata,
  output logic             busy,
  output logic             cle,
  output logic             ale,
  output logic             we_n,
  output logic             re_n,
  output logic [15:0]      io_out,
  output logic             io_oe,
  output logic [LEN_W-1:0] buf_off,
  output logic             buf_we_lo,
  output logic             buf_we_hi,
  output logic             stat_we,
  output logic             id_we
);
  bus_st_e         st;
  phase_e          ph, tgt;
  logic [LEN_W-1:0] idx;
  logic [7:0]      tcnt;

  logic        in_bus, rd_ph, pulse_end, capture, last_unit, wait_release, len_zero;
  logic [15:0] units;
  logic [7:0]  drv_byte;

  assign len_zero  = (len == '0);
  assign units     = phase_units(ph, 16'(len), wide);
  assign last_unit = (16'(idx) + 16'd1 >= units);
  assign tgt       = (st == S_IDLE) ? next_phase(mask, 4'd0, len_zero)
                                    : next_phase(mask, 4'(ph) + 4'd1, len_zero);
  assign in_bus    = st inside {S_SU, S_PW, S_HD};
  assign rd_ph     = is_read(ph);
  assign pulse_end = (st == S_PW) && (tcnt == 8'(T_PW - 1));
  assign capture   = pulse_end && rd_ph;
  assign wait_release = (st == S_WAIT) && (tcnt >= 8'(T_WB)) && rb_ready;

  always_comb begin
    case (ph)
      PH_CMD1: drv_byte = cmd_a;
      PH_CA1:  drv_byte = col[7:0];
      PH_CA2:  drv_byte = col[15:8];
      PH_RA1:  drv_byte = row[7:0];
      PH_RA2:  drv_byte = row[15:8];
      PH_RA3:  drv_byte = row[23:16];
      PH_CMD2: drv_byte = cmd_b;
      PH_CMD3: drv_byte = cmd_c;
      default: drv_byte = 8'h00;
    endcase
  end

  assign busy    = (st != S_IDLE);
  assign cle     = in_bus && is_cmd(ph);
  assign ale     = in_bus && is_addr(ph);
  assign we_n    = !((st == S_PW) && !rd_ph);
  assign re_n    = !((st == S_PW) && rd_ph);
  assign io_oe   = in_bus && !rd_ph;
  assign io_out  = !io_oe ? 16'h0000 :
                   (ph == PH_WDATA) ? (wide ? buf_rdata : {8'h00, buf_rdata[7:0]}) :
                   {8'h00, drv_byte};
  assign buf_off   = wide ? {idx[LEN_W-2:0], 1'b0} : idx;
  assign buf_we_lo = capture && (ph == PH_RDATA);
  assign buf_we_hi = buf_we_lo && wide;
  assign stat_we   = capture && (ph == PH_STAT);
  assign id_we     = capture && (ph == PH_ID);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      ph   <= PH_NONE;
      idx  <= '0;
      tcnt <= '0;
    end else begin
      logic go;
      go = 1'b0;
      case (st)
        S_IDLE: go = start;
        S_SU: if (tcnt == 8'(T_SU - 1)) begin tcnt <= '0; st <= S_PW; end
              else tcnt <= tcnt + 8'd1;
        S_PW: if (pulse_end) begin tcnt <= '0; st <= S_HD; end
              else tcnt <= tcnt + 8'd1;
        S_HD: if (tcnt == 8'(T_H - 1)) begin
                if (last_unit) go = 1'b1;
                else begin tcnt <= '0; idx <= idx + 1'b1; st <= S_SU; end
              end else tcnt <= tcnt + 8'd1;
        S_WAIT: if (wait_release) go = 1'b1;
                else if (tcnt < 8'(T_WB)) tcnt <= tcnt + 8'd1;
        default: st <= S_IDLE;
      endcase
      if (go) begin
        ph   <= tgt;
        idx  <= '0;
        tcnt <= '0;
        st   <= (tgt == PH_NONE) ? S_IDLE : (tgt == PH_WAIT) ? S_WAIT : S_SU;
      end
    end
  end

  // R2
  cle_ale_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(cle && ale));
  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(!we_n && !re_n));
  // R6
  no_drive_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n) !re_n |-> !io_oe);
  // R7
  wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT) |-> (we_n && re_n && !cle && !ale && !io_oe));
  // R7
  wait_exit_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == S_WAIT && st != S_WAIT) |-> $past(rb_ready));
  // R4
  pulse_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == S_PW && st == S_PW) |-> ($stable(io_out) && $stable(cle) && $stable(ale)));
  // R13
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (we_n && re_n && !io_oe && !cle && !ale));
endmodule

// File: rtl/nand_seq_top.sv
`timescale 1ns/1ps
module nand_seq_top #(
  parameter int NCE       = 4,
  parameter int NBUF      = 4,
  parameter int BUF_BYTES = 256,
  parameter int T_SU      = 2,
  parameter int T_PW      = 3,
  parameter int T_H       = 2,
  parameter int T_WB      = 4,
  localparam int LEN_W    = $clog2(BUF_BYTES) + 1,
  localparam int BYTE_AW  = $clog2(NBUF * BUF_BYTES),
  localparam int BUF_AW   = BYTE_AW - 2,
  localparam int BSEL_W   = $clog2(NBUF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              buf_we,
  input  logic [BUF_AW-1:0] buf_addr,
  input  logic [31:0]       buf_wdata,
  output logic [31:0]       buf_rdata,
  output logic              busy,
  output logic [NCE-1:0]    nand_ce_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [15:0]       nand_io_out,
  output logic              nand_io_oe,
  input  logic [15:0]       nand_io_in,
  input  logic [NCE-1:0]    nand_rb_n
);
  logic [15:0]      r_opc;
  logic [31:1]      r_ctrl;
  logic [15:0]      r_col;
  logic [31:0]      r_row;
  logic [LEN_W-1:0] r_len;
  logic             r_wide;
  logic [7:0]       r_stat;
  logic [31:0]      r_id;
  logic             start_q, eng_busy;

  logic [NCE-1:0]     rb_s;
  logic               rb_ready;
  logic [LEN_W-1:0]   eng_off;
  logic [BYTE_AW-1:0] eng_addr;
  logic [15:0]        eng_rdata;
  logic               we_lo, we_hi, stat_we, id_we;

  assign busy = eng_busy | start_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_opc <= '0; r_ctrl <= '0; r_col <= '0; r_row <= '0; r_len <= '0;
      r_wide <= 1'b0; r_stat <= '0; r_id <= '0; start_q <= 1'b0;
    end else begin
      start_q <= reg_we && !busy && (reg_addr == 3'd1) && reg_wdata[0];
      if (reg_we && !busy) begin
        case (reg_addr)
          3'd0: r_opc  <= reg_wdata[31:16];
          3'd1: r_ctrl <= reg_wdata[31:1];
          3'd2: r_col  <= reg_wdata[15:0];
          3'd3: r_row  <= reg_wdata;
          3'd4: r_len  <= reg_wdata[LEN_W-1:0];
          3'd5: r_wide <= reg_wdata[7];
          default: ;
        endcase
      end
      if (stat_we) r_stat <= nand_io_in[7:0];
      if (id_we)   r_id   <= {r_id[23:0], nand_io_in[7:0]};
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {r_opc, 16'h0000};
      3'd1:    reg_rdata = {r_ctrl, busy};
      3'd2:    reg_rdata = {16'h0000, r_col};
      3'd3:    reg_rdata = r_row;
      3'd4:    reg_rdata = 32'(r_len);
      3'd5:    reg_rdata = {24'h0, r_wide, 7'h00};
      3'd6:    reg_rdata = {24'h0, r_stat};
      default: reg_rdata = r_id;
    endcase
  end

  assign rb_ready  = &(rb_s | ~r_row[28 +: NCE]);
  assign nand_ce_n = busy ? ~r_row[24 +: NCE] : '1;
  assign eng_addr  = BYTE_AW'(r_ctrl[BSEL_W:1]) * BYTE_AW'(BUF_BYTES) + BYTE_AW'(eng_off);

  nseq_rb_sync #(.N(NCE)) u_sync (
    .clk(clk), .rst_n(rst_n), .rb_n_in(nand_rb_n), .rb_n_sync(rb_s));

  nseq_pagebuf #(.NBYTES(NBUF * BUF_BYTES)) u_buf (
    .clk(clk), .sw_we(buf_we), .sw_addr(buf_addr), .sw_wdata(buf_wdata),
    .sw_rdata(buf_rdata), .e_addr(eng_addr), .e_rdata(eng_rdata),
    .e_we_lo(we_lo), .e_we_hi(we_hi), .e_wdata(nand_io_in));

  nseq_engine #(.T_SU(T_SU), .T_PW(T_PW), .T_H(T_H), .T_WB(T_WB), .LEN_W(LEN_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start_q), .mask(r_ctrl[23:8]),
    .cmd_a(r_ctrl[31:24]), .cmd_b(r_opc[15:8]), .cmd_c(r_opc[7:0]),
    .col(r_col), .row(r_row[23:0]), .len(r_len), .wide(r_wide),
    .rb_ready(rb_ready), .io_in(nand_io_in), .buf_rdata(eng_rdata),
    .busy(eng_busy), .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n),
    .re_n(nand_re_n), .io_out(nand_io_out), .io_oe(nand_io_oe),
    .buf_off(eng_off), .buf_we_lo(we_lo), .buf_we_hi(we_hi),
    .stat_we(stat_we), .id_we(id_we));

  // R10
  ce_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (nand_ce_n == '1));
  // R12
  hold_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_we) |=> ($stable(r_ctrl) && $stable(r_row) && $stable(r_col) && $stable(r_len)));
  // R12
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n) !(start_q && eng_busy));
endmodule

// File: tb/tb_nand_seq_top.sv
`timescale 1ns/1ps
module tb_nand_seq_top;
  localparam int BUF_AW = 8;
  logic clk = 0, rst_n = 0;
  logic reg_we = 0, buf_we = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata, buf_wdata = 0, buf_rdata;
  logic [BUF_AW-1:0] buf_addr = 0;
  logic busy, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
  logic [3:0] nand_ce_n, nand_rb_n = 4'hF;
  logic [15:0] nand_io_out, nand_io_in;

  always #2.5 clk = ~clk;

  nand_seq_top dut (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .buf_we(buf_we), .buf_addr(buf_addr),
    .buf_wdata(buf_wdata), .buf_rdata(buf_rdata), .busy(busy), .nand_ce_n(nand_ce_n),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe), .nand_io_in(nand_io_in),
    .nand_rb_n(nand_rb_n));

  int n_chk = 0, n_fail = 0;
  // flash model: n-th byte read back is A0+n; every strobe rise is logged
  logic wide_tb = 0;
  int rd_ptr = 0, log_n = 0;
  logic [19:0] log_q [64];
  function automatic logic [7:0] fbyte(input int n); return 8'hA0 + 8'(n); endfunction
  assign nand_io_in = wide_tb ? {fbyte(rd_ptr + 1), fbyte(rd_ptr)} : {8'h00, fbyte(rd_ptr)};

  always @(posedge nand_we_n) if (rst_n && log_n < 64) begin
    log_q[log_n] = {1'b0, nand_io_oe, nand_cle, nand_ale, nand_io_out}; log_n++;
  end
  always @(posedge nand_re_n) if (rst_n) begin
    if (log_n < 64) begin log_q[log_n] = {1'b1, nand_io_oe, nand_cle, nand_ale, 16'h0}; log_n++; end
    rd_ptr += wide_tb ? 2 : 1;
  end

  // strobe width / gap monitor
  int lc = 0, hc = 0, wmin = 999, wmax = 0, gmin = 999, gmax = 0;
  logic seen = 0;
  always @(negedge clk) if (busy) begin
    if (!nand_we_n) begin
      if (seen && hc > 0) begin
        if (hc < gmin) gmin = hc;
        if (hc > gmax) gmax = hc;
      end
      lc++; hc = 0;
    end else begin
      if (lc > 0) begin
        if (lc < wmin) wmin = lc;
        if (lc > wmax) wmax = lc;
        lc = 0; seen = 1;
      end
      hc++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #0.1; d = reg_rdata;
  endtask

  task automatic wr_buf(input int w, input logic [31:0] d);
    @(negedge clk); buf_we = 1; buf_addr = BUF_AW'(w); buf_wdata = d;
    @(negedge clk); buf_we = 0;
  endtask

  task automatic rd_buf(input int w, output logic [31:0] d);
    buf_addr = BUF_AW'(w); #0.1; d = buf_rdata;
  endtask

  task automatic start_op(input logic [31:0] ctrl);
    log_n = 0; rd_ptr = 0; lc = 0; hc = 0; seen = 0;
    wmin = 999; wmax = 0; gmin = 999; gmax = 0;
    wr_reg(3'd1, ctrl);
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (busy && n < 5000) begin @(negedge clk); n++; end
    check(req, 32'(busy), 32'd0);
  endtask

  function automatic logic [31:0] we_ent(input logic c, input logic a, input logic [15:0] io);
    return 32'({1'b0, 1'b1, c, a, io});
  endfunction

  task automatic t_reset;
    check("R13 cle/ale/we_n/re_n/oe/busy", {26'h0, nand_cle, nand_ale, nand_we_n, nand_re_n,
          nand_io_oe, busy}, 32'h0000_000C);
    check("R13 ce_n", 32'(nand_ce_n), 32'hF);
  endtask

  task automatic t_cmd_addr;
    logic [31:0] d;
    wr_reg(3'd0, 32'h1000_0000);
    wr_reg(3'd2, 32'h0000_BEEF);
    wr_reg(3'd3, 32'h0112_3456);
    start_op(32'h857E_8001);
    check("R11 busy after start", 32'(busy), 32'd1);
    rd_reg(3'd1, d);
    check("R11 busy bit read", 32'(d[0]), 32'd1);
    repeat (5) @(negedge clk);
    check("R10 ce_n while busy", 32'(nand_ce_n), 32'hE);
    wait_idle("R11 done");
    check("R10 ce_n idle", 32'(nand_ce_n), 32'hF);
    check("R1 cycle count", 32'(log_n), 32'd7);
    check("R2 cmd1", 32'(log_q[0]), we_ent(1, 0, 16'h0085));
    check("R3 col lo", 32'(log_q[1]), we_ent(0, 1, 16'h00EF));
    check("R3 col hi", 32'(log_q[2]), we_ent(0, 1, 16'h00BE));
    check("R3 row 1", 32'(log_q[3]), we_ent(0, 1, 16'h0056));
    check("R3 row 2", 32'(log_q[4]), we_ent(0, 1, 16'h0034));
    check("R3 row 3", 32'(log_q[5]), we_ent(0, 1, 16'h0012));
    check("R2 cmd2", 32'(log_q[6]), we_ent(1, 0, 16'h0010));
    check("R4 pulse min", 32'(wmin), 32'd3);
    check("R4 pulse max", 32'(wmax), 32'd3);
    check("R4 gap min", 32'(gmin), 32'd4);
    check("R4 gap max", 32'(gmax), 32'd4);
  endtask

  task automatic t_write_data;
    wr_buf(64, 32'h1112_1314);
    wr_buf(65, 32'h1516_0000);
    wr_reg(3'd4, 32'd6);
    start_op(32'h8041_8003);
    wait_idle("R5 done");
    check("R5 cycle count", 32'(log_n), 32'd8);
    check("R5 cmd first", 32'(log_q[0]), we_ent(1, 0, 16'h0080));
    for (int i = 0; i < 6; i++)
      check("R5 data byte", 32'(log_q[1+i]), we_ent(0, 0, 16'h0011 + 16'(i)));
    check("R1 cmd2 after data", 32'(log_q[7]), we_ent(1, 0, 16'h0010));
  endtask

  task automatic t_read_data;
    logic [31:0] d;
    wr_reg(3'd0, 32'h3000_0000);
    wr_reg(3'd4, 32'd7);
    start_op(32'h0040_A005);
    wait_idle("R6 done");
    check("R6 cycle count", 32'(log_n), 32'd9);
    check("R1 cmd1 before read", 32'(log_q[0]), we_ent(1, 0, 16'h0000));
    check("R1 cmd2 before read", 32'(log_q[1]), we_ent(1, 0, 16'h0030));
    check("R6 read no drive", 32'(log_q[2]), 32'h8_0000);
    rd_buf(128, d);
    check("R6 buffer word 0", d, 32'hA0A1_A2A3);
    rd_buf(129, d);
    check("R6 buffer word 1", {d[31:8], 8'h00}, 32'hA4A5_A600);
  endtask

  task automatic t_wide;
    logic [31:0] d;
    wr_reg(3'd5, 32'h80);
    wide_tb = 1;
    wr_buf(0, 32'h2122_2324);
    wr_reg(3'd4, 32'd4);
    start_op(32'h8041_0001);
    wait_idle("R9 write done");
    check("R9 write count", 32'(log_n), 32'd3);
    check("R9 cmd stays 8 bit", 32'(log_q[0]), we_ent(1, 0, 16'h0080));
    check("R9 word 0", 32'(log_q[1]), we_ent(0, 0, 16'h2221));
    check("R9 word 1", 32'(log_q[2]), we_ent(0, 0, 16'h2423));
    start_op(32'h0000_2007);
    wait_idle("R9 read done");
    check("R9 read cycles", 32'(log_n), 32'd2);
    rd_buf(192, d);
    check("R9 read packing", d, 32'hA0A1_A2A3);
    wr_reg(3'd5, 32'h0);
    wide_tb = 0;
  endtask

  task automatic t_zero_len;
    wr_reg(3'd0, 32'h1000_0000);
    wr_reg(3'd4, 32'd0);
    start_op(32'h8041_8001);
    wait_idle("R14 done");
    check("R14 no data cycles", 32'(log_n), 32'd2);
    check("R14 second is cmd", 32'(log_q[1]), we_ent(1, 0, 16'h0010));
  endtask

  task automatic t_wait;
    logic [31:0] d;
    wr_reg(3'd0, 32'h00D0_0000);
    wr_reg(3'd2, 32'h0000_0000);
    wr_reg(3'd3, 32'h2100_0000);
    nand_rb_n = 4'b1101;
    start_op(32'h6040_5001);
    repeat (60) @(negedge clk);
    check("R7 stalled on busy line", 32'(log_n), 32'd1);
    check("R7 still busy", 32'(busy), 32'd1);
    check("R10 ce_n during wait", 32'(nand_ce_n), 32'hE);
    wr_reg(3'd1, 32'h1111_1111);
    wr_reg(3'd2, 32'h0000_1234);
    repeat (10) @(negedge clk);
    nand_rb_n = 4'hF;
    wait_idle("R7 released");
    check("R7 cmd3 after wait", 32'(log_n), 32'd2);
    check("R7 cmd3 value", 32'(log_q[1]), we_ent(1, 0, 16'h00D0));
    rd_reg(3'd1, d);
    check("R12 ctrl kept", d, 32'h6040_5000);
    rd_reg(3'd2, d);
    check("R12 col kept", d, 32'h0);
    nand_rb_n = 4'b1011;
    start_op(32'h6040_5001);
    repeat (40) @(negedge clk);
    check("R7 unselected line ignored", 32'(busy), 32'd0);
    check("R7 unselected count", 32'(log_n), 32'd2);
    nand_rb_n = 4'hF;
  endtask

  task automatic t_status_id;
    logic [31:0] d;
    start_op(32'h0000_0C01);
    wait_idle("R8 done");
    check("R8 read cycles", 32'(log_n), 32'd5);
    rd_reg(3'd6, d);
    check("R8 status", d, 32'h0000_00A0);
    rd_reg(3'd7, d);
    check("R8 id", d, 32'hA1A2_A3A4);
  endtask

  task automatic t_empty;
    start_op(32'h0000_0001);
    check("R11 empty busy one cycle", 32'(busy), 32'd1);
    @(negedge clk);
    check("R11 empty back idle", 32'(busy), 32'd0);
    check("R1 empty no cycles", 32'(log_n), 32'd0);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R11 watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_cmd_addr();
    t_write_data();
    t_read_data();
    t_wide();
    t_zero_len();
    t_wait();
    t_status_id();
    t_empty();
    summary();
    $finish;
  end
endmodule